// File: doc/BRIEF.md
# Transmit Gating and Bus Fault Diagnosis

This block is the digital control core placed between a communication controller and the analog front end of a differential two-wire bus transceiver. It decides, every clock cycle, whether the line driver may run and which symbol it sends. The driver runs only in the active operating mode, with the guardian permission high and the active-low transmit request asserted. A timeout guard and an over-temperature guard can force the driver off.

Around the driver it collects fault evidence. An echo tracker compares edges sent on the transmit data line with edges that come back on the receive line. Four current comparators, one for each driver side, are sampled only once the driven symbol has settled for a configurable window. A differential-voltage comparator is sampled once per symbol to detect the two wires shorted together. Open-line and short-to-supply/ground indications are formed by combining the sampled current flags for each wire. All flags are merged with the I/O under-voltage flag into one error output. A separate active-low pin shows that merged error only while the block is in the active mode.

No data stream crosses this block with flow control. Transmit data is a bit-level line sampled every cycle, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal. Timeout and settle windows are counted in clock cycles.

Top module: `tx_gate_diag`

## Requirements
- R1: Mode encoding is 0 = power-off, 1 = standby, 2 = active. `drv_en_o` is high only when the mode is active, `guard_en_i` is 1, `txen_n_i` is 0, and neither the timeout flag nor the over-temperature flag is set. While enabled, `bus_sym_o` is 2'b10 (plus wire high) for `txd_i`=1 and 2'b01 for `txd_i`=0. Otherwise it is 2'b00 (idle, undriven). These outputs respond combinationally.
- R2: `ot_flag_o` follows `ot_i` one clock later outside power-off. While it is set, the driver is off.
- R3: After `drv_en_o` has been high for `TIMEOUT_CYC` consecutive cycles, `timeout_o` sets on the next edge and the driver turns off.
- R4: `timeout_o` clears on the edge following any change of `txen_n_i` or `guard_en_i`, or any cycle outside the active mode.
- R5: `bus_err_o` sets when two transmit rising edges occur with no receive rising edge between them, or when two transmit falling edges occur with no receive falling edge between them. Edges seen while the driver is off are ignored, and the flag holds its value.
- R6: `bus_err_o` clears when a transmit rising (falling) edge is followed by a receive rising (falling) edge before the next transmit edge of the same polarity.
- R7: Side index 0 is plus-high, 1 is plus-low, 2 is minus-high and 3 is minus-low. Each bit of `lo_flag_o`/`hi_flag_o` loads its comparator input only while the driver is on and the same symbol has been held for more than `STABLE_CYC` cycles. Sides 0 and 3 load during symbol 2'b10; sides 1 and 2 load during symbol 2'b01.
- R8: Wire index 0 is plus and 1 is minus. `open_o` = low-current on both sides of the wire. `short_sup_o` = low high-side current AND high low-side current. `short_gnd_o` = high high-side current AND low low-side current.
- R9: `short_lines_o` loads `short_cmp_i` exactly once per held symbol, when the symbol has been held `STABLE_CYC` cycles. Later changes of the comparator during the same symbol are ignored.
- R10: `err_any_o` is the OR of all flags and `uv_io_i`. `err_n_o` = NOT `err_any_o` in the active mode and is 1 in other modes.
- R11: One clock in power-off clears every stored flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode (0 off, 1 standby, 2 active) |
| txd_i | input | 1 | Transmit data bit |
| txen_n_i | input | 1 | Transmit request, active low |
| guard_en_i | input | 1 | Guardian permission, active high |
| rxd_i | input | 1 | Received data loopback |
| lo_cur_i | input | 4 | Low-current comparators per side |
| hi_cur_i | input | 4 | High-current comparators per side |
| short_cmp_i | input | 1 | Differential magnitude below short threshold |
| ot_i | input | 1 | Over-temperature comparator |
| uv_io_i | input | 1 | I/O supply under-voltage flag |
| drv_en_o | output | 1 | Line driver enable |
| bus_sym_o | output | 2 | Driven symbol (00 idle, 01 Data0, 10 Data1) |
| timeout_o | output | 1 | Enable timeout flag |
| ot_flag_o | output | 1 | Over-temperature flag |
| bus_err_o | output | 1 | Echo mismatch flag |
| lo_flag_o | output | 4 | Sampled low-current flags |
| hi_flag_o | output | 4 | Sampled high-current flags |
| open_o | output | 2 | Open wire per line |
| short_sup_o | output | 2 | Short to supply per line |
| short_gnd_o | output | 2 | Short to ground per line |
| short_lines_o | output | 1 | Wires shorted together |
| err_any_o | output | 1 | Combined error |
| err_n_o | output | 1 | Combined error pin, active low |

## Verification
A wrong internal state shows up at the ports in different ways. A stuck timeout counter or flag shows on `drv_en_o` in the same cycle as the mistake, since the driver enable is combinational from the stored flags. A lost echo pending bit does not show until the next same-polarity transmit edge, one edge after it reaches `bus_err_o`. A wrong settle counter moves the load of the current flags by whole cycles, so the bench samples one cycle before and one cycle after the expected load edge.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam logic [1:0] MD_OFF  = 2'd0;
  localparam logic [1:0] MD_STBY = 2'd1;
  localparam logic [1:0] MD_NORM = 2'd2;

  localparam logic [1:0] SYM_IDLE = 2'b00;
  localparam logic [1:0] SYM_D0   = 2'b01;
  localparam logic [1:0] SYM_D1   = 2'b10;

  localparam int SIDES = 4;
  localparam int LINES = 2;

  // symbol under which a driver side carries current
  function automatic logic [1:0] side_qual(input int side);
    return (side == 0 || side == 3) ? SYM_D1 : SYM_D0;
  endfunction
endpackage

// File: rtl/txg_gate.sv
module txg_gate
  import txg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       guard_en_i,
  input  logic       txen_n_i,
  input  logic       txd_i,
  input  logic       ot_i,
  output logic       drv_en_o,
  output logic [1:0] sym_o,
  output logic       timeout_o,
  output logic       ot_flag_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;
  logic to_q, ot_q, txen_q, guard_q;
  logic is_norm, req, ctl_edge;

  assign is_norm  = (mode_i == MD_NORM);
  assign req      = is_norm & guard_en_i & ~txen_n_i;
  assign ctl_edge = (txen_n_i ^ txen_q) | (guard_en_i ^ guard_q);
  assign drv_en_o = req & ~to_q & ~ot_q;
  assign sym_o    = !drv_en_o ? SYM_IDLE : (txd_i ? SYM_D1 : SYM_D0);

  assign timeout_o = to_q;
  assign ot_flag_o = ot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      to_q    <= 1'b0;
      ot_q    <= 1'b0;
      txen_q  <= 1'b1;
      guard_q <= 1'b0;
    end else begin
      txen_q  <= txen_n_i;
      guard_q <= guard_en_i;
      ot_q    <= (mode_i != MD_OFF) & ot_i;
      if (!is_norm || ctl_edge) begin
        to_q <= 1'b0;
        cnt  <= drv_en_o ? CW'(1) : '0;
      end else if (drv_en_o) begin
        if (cnt == CNT_LAST) begin
          to_q <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/txg_echo.sv
module txg_echo
  import txg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       drv_en_i,
  input  logic       txd_i,
  input  logic       rxd_i,
  output logic       bus_err_o
);
  logic txd_q, rxd_q, pend_r, pend_f, err_q;
  logic txr, txf, rxr, rxf, set_e, clr_e;

  assign txr = txd_i & ~txd_q;
  assign txf = ~txd_i & txd_q;
  assign rxr = rxd_i & ~rxd_q;
  assign rxf = ~rxd_i & rxd_q;

  // a second same-polarity transmit edge while the first is unanswered
  assign set_e = (txr & pend_r & ~rxr) | (txf & pend_f & ~rxf);
  assign clr_e = (rxr & (pend_r | txr)) | (rxf & (pend_f | txf));

  assign bus_err_o = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q  <= 1'b1;
      rxd_q  <= 1'b1;
      pend_r <= 1'b0;
      pend_f <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      txd_q <= txd_i;
      rxd_q <= rxd_i;
      if (mode_i == MD_OFF) begin
        pend_r <= 1'b0;
        pend_f <= 1'b0;
        err_q  <= 1'b0;
      end else if (drv_en_i) begin
        pend_r <= (pend_r | txr) & ~rxr;
        pend_f <= (pend_f | txf) & ~rxf;
        if (set_e)      err_q <= 1'b1;
        else if (clr_e) err_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txg_diag.sv
module txg_diag
  import txg_pkg::*;
#(
  parameter int STABLE_CYC = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             drv_en_i,
  input  logic [1:0]       sym_i,
  input  logic [SIDES-1:0] lo_cur_i,
  input  logic [SIDES-1:0] hi_cur_i,
  input  logic             short_cmp_i,
  output logic [SIDES-1:0] lo_flag_o,
  output logic [SIDES-1:0] hi_flag_o,
  output logic             short_lines_o
);
  localparam int SW = $clog2(STABLE_CYC + 1);
  localparam logic [SW-1:0] ST_MAX  = SW'(STABLE_CYC);
  localparam logic [SW-1:0] ST_LAST = SW'(STABLE_CYC - 1);

  logic [SW-1:0] cnt;
  logic [1:0]    sym_q;
  logic          held, settled, short_pt, is_off;

  assign is_off   = (mode_i == MD_OFF);
  assign held     = drv_en_i && (sym_i == sym_q);
  assign settled  = held && (cnt == ST_MAX);
  assign short_pt = held && (cnt == ST_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sym_q <= SYM_IDLE;
    end else begin
      sym_q <= sym_i;
      if (!held)              cnt <= '0;
      else if (cnt != ST_MAX) cnt <= cnt + 1'b1;
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam logic [1:0] QUAL = side_qual(s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_flag_o[s] <= 1'b0;
        hi_flag_o[s] <= 1'b0;
      end else if (is_off) begin
        lo_flag_o[s] <= 1'b0;
        hi_flag_o[s] <= 1'b0;
      end else if (settled && sym_i == QUAL) begin
        lo_flag_o[s] <= lo_cur_i[s];
        hi_flag_o[s] <= hi_cur_i[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        short_lines_o <= 1'b0;
    else if (is_off)   short_lines_o <= 1'b0;
    else if (short_pt) short_lines_o <= short_cmp_i;
  end
endmodule

// File: rtl/tx_gate_diag.sv
module tx_gate_diag
  import txg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64000,
  parameter int STABLE_CYC  = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       txd_i,
  input  logic       txen_n_i,
  input  logic       guard_en_i,
  input  logic       rxd_i,
  input  logic [3:0] lo_cur_i,
  input  logic [3:0] hi_cur_i,
  input  logic       short_cmp_i,
  input  logic       ot_i,
  input  logic       uv_io_i,
  output logic       drv_en_o,
  output logic [1:0] bus_sym_o,
  output logic       timeout_o,
  output logic       ot_flag_o,
  output logic       bus_err_o,
  output logic [3:0] lo_flag_o,
  output logic [3:0] hi_flag_o,
  output logic [1:0] open_o,
  output logic [1:0] short_sup_o,
  output logic [1:0] short_gnd_o,
  output logic       short_lines_o,
  output logic       err_any_o,
  output logic       err_n_o
);
  txg_gate #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .guard_en_i(guard_en_i),
    .txen_n_i(txen_n_i), .txd_i(txd_i), .ot_i(ot_i),
    .drv_en_o(drv_en_o), .sym_o(bus_sym_o),
    .timeout_o(timeout_o), .ot_flag_o(ot_flag_o)
  );

  txg_echo u_echo (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .drv_en_i(drv_en_o),
    .txd_i(txd_i), .rxd_i(rxd_i), .bus_err_o(bus_err_o)
  );

  txg_diag #(.STABLE_CYC(STABLE_CYC)) u_diag (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .drv_en_i(drv_en_o),
    .sym_i(bus_sym_o), .lo_cur_i(lo_cur_i), .hi_cur_i(hi_cur_i),
    .short_cmp_i(short_cmp_i), .lo_flag_o(lo_flag_o),
    .hi_flag_o(hi_flag_o), .short_lines_o(short_lines_o)
  );

  // wire w: high side is index 2w, low side is index 2w+1
  for (genvar w = 0; w < LINES; w++) begin : g_line
    assign open_o[w]      = lo_flag_o[2*w] & lo_flag_o[2*w+1];
    assign short_sup_o[w] = lo_flag_o[2*w] & hi_flag_o[2*w+1];
    assign short_gnd_o[w] = hi_flag_o[2*w] & lo_flag_o[2*w+1];
  end

  assign err_any_o = bus_err_o | timeout_o | ot_flag_o | (|lo_flag_o) |
                     (|hi_flag_o) | short_lines_o | uv_io_i;
  assign err_n_o   = ~((mode_i == MD_NORM) & err_any_o);
endmodule

// File: rtl/txg_chk.sv
module txg_chk
  import txg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       txd_i,
  input logic       txen_n_i,
  input logic       guard_en_i,
  input logic       drv_en_o,
  input logic [1:0] bus_sym_o,
  input logic       timeout_o,
  input logic       ot_flag_o,
  input logic       bus_err_o,
  input logic [3:0] lo_flag_o,
  input logic [3:0] hi_flag_o,
  input logic       short_lines_o,
  input logic       err_n_o
);
  AST_GATE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en_o |-> (mode_i == MD_NORM && guard_en_i && !txen_n_i)); // R1
  AST_SYM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en_o |-> (bus_sym_o == SYM_IDLE)); // R1
  AST_SYM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en_o |-> (bus_sym_o == (txd_i ? SYM_D1 : SYM_D0))); // R1
  AST_OT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag_o |-> !drv_en_o); // R2
  AST_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !drv_en_o); // R3
  AST_TO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MD_NORM) |=> !timeout_o); // R4
  AST_BUSERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en_o && mode_i != MD_OFF) |=> $stable(bus_err_o)); // R5
  AST_ERRN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MD_NORM) |-> err_n_o); // R10
  AST_OFF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_OFF) |=> (!bus_err_o && !timeout_o && !ot_flag_o &&
                            lo_flag_o == 4'd0 && hi_flag_o == 4'd0 &&
                            !short_lines_o)); // R11
endmodule

bind tx_gate_diag txg_chk u_chk (.*);

// File: tb/sim_tx_gate_diag.sv
`timescale 1ns/1ps
module sim_tx_gate_diag;
  localparam int TO = 64;
  localparam int ST = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic txd_i = 1'b1, txen_n_i = 1'b1, guard_en_i = 1'b0, rxd_i = 1'b1;
  logic [3:0] lo_cur_i = '0, hi_cur_i = '0;
  logic short_cmp_i = 1'b0, ot_i = 1'b0, uv_io_i = 1'b0;
  logic drv_en_o, timeout_o, ot_flag_o, bus_err_o, short_lines_o, err_any_o, err_n_o;
  logic [1:0] bus_sym_o, open_o, short_sup_o, short_gnd_o;
  logic [3:0] lo_flag_o, hi_flag_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tx_gate_diag #(.TIMEOUT_CYC(TO), .STABLE_CYC(ST)) u0 (.*);

  // {mode, guard, txen_n, txd, exp_en, exp_sym}
  localparam logic [7:0] VEC [8] = '{
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 2'b10},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01},
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00},
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 2'b10},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // reset state (R11, R10)
    chk("R1 reset drv_en", drv_en_o, 0);
    chk("R1 reset sym", bus_sym_o, 0);
    chk("R11 reset flags", {bus_err_o, timeout_o, ot_flag_o, short_lines_o, lo_flag_o, hi_flag_o}, 0);
    chk("R10 reset err_n", err_n_o, 1);

    // R1 gating table
    foreach (VEC[i]) begin
      {mode_i, guard_en_i, txen_n_i, txd_i} = VEC[i][7:3];
      #1;
      chk($sformatf("R1 vec%0d en", i), drv_en_o, VEC[i][2]);
      chk($sformatf("R1 vec%0d sym", i), bus_sym_o, VEC[i][1:0]);
      tick();
    end

    // R3 timeout length
    mode_i = 2'd1; tick();
    mode_i = 2'd2; guard_en_i = 1; txen_n_i = 0; txd_i = 1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      #2; if (drv_en_o) n++;
      tick();
    end
    chk("R3 enabled cycles", n, TO);
    chk("R3 timeout set", timeout_o, 1);
    // R4 clear on txen change
    txen_n_i = 1; tick();
    chk("R4 clear on txen edge", timeout_o, 0);
    txen_n_i = 0; #1;
    chk("R4 driver back", drv_en_o, 1);
    repeat (TO + 2) tick();
    chk("R3 timeout again", timeout_o, 1);
    mode_i = 2'd1; tick();
    chk("R4 clear leaving active", timeout_o, 0);

    // R2 over-temperature
    mode_i = 2'd2; tick();
    ot_i = 1; tick();
    chk("R2 ot flag", ot_flag_o, 1);
    chk("R2 driver off", drv_en_o, 0);
    ot_i = 0; tick();
    chk("R2 ot clear", ot_flag_o, 0);
    chk("R2 driver on", drv_en_o, 1);

    // R5/R6 echo tracking
    mode_i = 2'd0; txd_i = 0; rxd_i = 0; tick();
    mode_i = 2'd2; txen_n_i = 1; tick();
    txen_n_i = 0; tick();
    txd_i = 1; tick();
    txd_i = 0; tick();
    chk("R5 single edges", bus_err_o, 0);
    txd_i = 1; tick();
    chk("R5 two rises no echo", bus_err_o, 1);
    rxd_i = 1; tick();
    chk("R6 rise echo clears", bus_err_o, 0);
    txen_n_i = 1;
    for (int i = 0; i < 2; i++) begin
      txd_i = 0; tick();
      txd_i = 1; tick();
    end
    chk("R5 ignored while off", bus_err_o, 0);
    txen_n_i = 0; tick();
    txd_i = 0; tick();
    chk("R5 two falls no echo", bus_err_o, 1);
    rxd_i = 0; tick();
    chk("R6 fall echo clears", bus_err_o, 0);

    // R7/R8/R9 current and short sampling
    mode_i = 2'd0; tick();
    mode_i = 2'd2; txen_n_i = 1; tick();
    lo_cur_i = 4'b1111; hi_cur_i = 4'b0000; short_cmp_i = 1;
    txd_i = 1; txen_n_i = 0;
    repeat (ST + 1) tick();
    chk("R7 not before window", lo_flag_o, 4'b0000);
    chk("R9 short sampled", short_lines_o, 1);
    tick();
    chk("R7 Data1 sides", lo_flag_o, 4'b1001);
    chk("R8 open plus only one side", open_o, 2'b00);
    txd_i = 0;
    repeat (ST + 1) tick();
    chk("R7 Data0 window", lo_flag_o, 4'b1001);
    tick();
    chk("R7 Data0 sides", lo_flag_o, 4'b1111);
    chk("R8 open both", open_o, 2'b11);
    lo_cur_i = 4'b0000; hi_cur_i = 4'b0110; short_cmp_i = 0;
    tick(); tick();
    chk("R7 lo mix", lo_flag_o, 4'b1001);
    chk("R7 hi mix", hi_flag_o, 4'b0110);
    chk("R8 open none", open_o, 2'b00);
    chk("R8 short supply", short_sup_o, 2'b01);
    chk("R8 short ground", short_gnd_o, 2'b10);
    chk("R9 sampled once", short_lines_o, 1);
    chk("R10 err_n active", err_n_o, 0);
    chk("R10 err_any", err_any_o, 1);
    mode_i = 2'd1; #1;
    chk("R10 err_n standby", err_n_o, 1);

    // R11 power-off clear
    mode_i = 2'd0; tick();
    chk("R11 flags cleared", {bus_err_o, timeout_o, ot_flag_o, short_lines_o, lo_flag_o, hi_flag_o}, 0);
    chk("R11 err_any", err_any_o, 0);
    uv_io_i = 1; mode_i = 2'd2; txen_n_i = 1; #1;
    chk("R10 uv in combine", err_n_o, 0);
    tick();
    finish_run();
  end
endmodule